// File: doc/BRIEF.md
# Scrambled-Map 64-Source Interrupt Controller

This block collects up to 63 active-low interrupt request lines (source numbers 1 to 63; number 0 is reserved to mean "nothing pending"). It drives one combined interrupt output towards a processor. Each source owns one mask bit and one pending bit. These bits sit in a pair of 32-bit words called high and low. A fixed table places each source at its word and bit, and that position is not the source number. Software reaches the mask words, the pending words, a sense-select word and a read-only vector word over a simple 32-bit register port. Writes to that port take effect at the clock edge, and reads are combinational.

Internal sources are level-sensitive and active low. Two groups can instead be switched to latch a falling edge: external sources 19 to 25 and port sources 48 to 63. The vector word reports the lowest-numbered source that is both pending and unmasked, so software can go straight to the right handler. Software then clears the source by writing 1 to its pending bit.

Top module: `sirq_ctrl`

## Requirements
- R1: A synchronous active-high reset clears both mask words, both pending words and the sense word. The vector word then reads 0 and `irq_o` is 0.
- R2: Source positions, as (word, bit): 1..15 go to low bit 16-s. 16..18 go to high bit 18-s. 19..30 go to high bit 33-s. 31 goes to high bit 15. 32..47 go to low bit 63-s. 48..63 go to high bit s-32. Low bit 0 belongs to no source and reads 0 in the pending word.
- R3: Register addresses on `bus_addr_i`: 0 is mask high, 1 is mask low, 2 is pending high, 3 is pending low, 4 is sense, 5 is vector. Both mask words read back exactly what was written.
- R4: Writing 1 to a pending bit clears an edge-latched bit, and writing 0 leaves it alone. A level-mode bit keeps following its input, so a write of 1 to it has no lasting effect.
- R5: In level mode the pending bit equals the inverted input after a two-stage synchronizer. An input change that comes before clock edge k shows in the pending word after edge k+2.
- R6: In edge mode a high-to-low transition of the synchronized input sets the pending bit, with the same latency as R5. The bit stays set after the input returns high. A line held low does not set it again after a clear.
- R7: Sense word bit 33-s selects edge mode (1) or level mode (0) for external source s in 19..25. Bit 79-s does the same for port source s in 48..63. All other sense bits read 0, and all other sources are always in level mode.
- R8: The vector word holds, in bits 31:26, the lowest-numbered source that is pending with its mask bit at 1. It reads 0 when no such source exists, and its bits 25:0 are always 0.
- R9: `irq_o` is 1 exactly one clock after some source is pending and unmasked, and 0 one clock after none is.
- R10: Writes to address 5, 6 or 7 change nothing. Reads of addresses 6 and 7 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| irq_n_i | input | 64 | Active-low request lines, index = source number (index 0 unused) |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 3 | Register word address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Combinational read data for `bus_addr_i` |
| irq_o | output | 1 | Combined registered interrupt request |

## Verification
If the mapping table or the sense decode is wrong, the fault appears in the pending word as a bit in the wrong place. It shows three clocks after the line drops, and the vector word can then name the wrong source. An edge latch that fails to hold, or that clears on the wrong bit, shows in the same window at the pending read after a write-1. A wrong priority order or a lost mask bit changes the vector word at once, and changes `irq_o` one clock later. The bench therefore compares `irq_o` and the vector word against its own model on every clock, not only at the end of each scenario.

// File: rtl/sirq_pkg.sv
package sirq_pkg;

    localparam int NUM_SRC = 64;
    localparam int WORD_W  = 32;
    localparam int VEC_W   = $clog2(NUM_SRC);
    localparam int VEC_LSB = WORD_W - VEC_W;

    // Source 0 is reserved: it means "no interrupt" in the vector word.
    localparam logic [NUM_SRC-1:0] SRC_USED = {{(NUM_SRC-1){1'b1}}, 1'b0};

    typedef enum logic [2:0] {
        A_MASK_HI = 3'd0,
        A_MASK_LO = 3'd1,
        A_PEND_HI = 3'd2,
        A_PEND_LO = 3'd3,
        A_SENSE   = 3'd4,
        A_VECTOR  = 3'd5
    } reg_addr_e;

    typedef struct packed {
        logic       valid;
        logic       hi;
        logic [4:0] pos;
    } slot_t;

    // Fixed word/bit placement of each source.
    function automatic slot_t slot_of(input int s);
        slot_t r;
        r = '{valid: 1'b1, hi: 1'b0, pos: 5'd0};
        if (s <= 0 || s >= NUM_SRC) r.valid = 1'b0;
        else if (s <= 15) begin r.hi = 1'b0; r.pos = 5'(16 - s); end
        else if (s <= 18) begin r.hi = 1'b1; r.pos = 5'(18 - s); end
        else if (s <= 30) begin r.hi = 1'b1; r.pos = 5'(33 - s); end
        else if (s == 31) begin r.hi = 1'b1; r.pos = 5'd15;      end
        else if (s <= 47) begin r.hi = 1'b0; r.pos = 5'(63 - s); end
        else              begin r.hi = 1'b1; r.pos = 5'(s - 32); end
        return r;
    endfunction

    // Sense-select placement: external group and port group.
    function automatic logic has_sense(input int s);
        return (s >= 19 && s <= 25) || (s >= 48 && s <= 63);
    endfunction

    function automatic logic [4:0] sense_pos(input int s);
        if (s >= 19 && s <= 25) return 5'(33 - s);
        if (s >= 48 && s <= 63) return 5'(79 - s);
        return 5'd0;
    endfunction

    function automatic logic [WORD_W-1:0] sense_writable();
        logic [WORD_W-1:0] m;
        m = '0;
        for (int s = 0; s < NUM_SRC; s++)
            if (has_sense(s)) m[sense_pos(s)] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/sirq_sync.sv
module sirq_sync #(
    parameter int W      = 64,
    parameter int STAGES = 2
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stage_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk_i) begin
            if (rst_i)       stage_q[g] <= '1;
            else if (g == 0) stage_q[g] <= d_i;
            else             stage_q[g] <= stage_q[(g == 0) ? 0 : g - 1];
        end
    end

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/sirq_pend.sv
module sirq_pend
    import sirq_pkg::*;
(
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic [NUM_SRC-1:0] sync_n_i,
    input  logic [NUM_SRC-1:0] edge_sel_i,
    input  logic [NUM_SRC-1:0] clr_i,
    output logic [NUM_SRC-1:0] pend_o
);
    logic [NUM_SRC-1:0] pend_q, prev_n_q, fall, nxt;

    assign fall = prev_n_q & ~sync_n_i;

    always_comb begin
        nxt = (edge_sel_i & ((pend_q & ~clr_i) | fall))
            | (~edge_sel_i & ~sync_n_i);
        nxt = nxt & SRC_USED;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            pend_q   <= '0;
            prev_n_q <= '1;
        end else begin
            pend_q   <= nxt;
            prev_n_q <= sync_n_i;
        end
    end

    assign pend_o = pend_q;

    // R5: level-mode bits mirror the inverted synchronized input
    p_level_follow_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        ((pend_q ^ ~$past(sync_n_i)) & $past(~edge_sel_i & SRC_USED)) == '0);

    // R6: an edge-latched bit that was not cleared stays set
    p_edge_hold_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        ($past(pend_q & edge_sel_i & ~clr_i) & ~pend_q) == '0);

    // R2: the reserved source 0 never becomes pending
    p_src0_idle_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        !pend_q[0]);
endmodule

// File: rtl/sirq_prio.sv
module sirq_prio
    import sirq_pkg::*;
(
    input  logic [NUM_SRC-1:0] active_i,
    output logic [VEC_W-1:0]   vec_o
);
    always_comb begin
        vec_o = '0;
        for (int s = NUM_SRC - 1; s >= 1; s--)
            if (active_i[s]) vec_o = VEC_W'(s);
    end

    // R8: a reported source is active and nothing lower-numbered is
    always_comb begin
        if (vec_o != '0) begin
            p_vec_active_r8: assert (active_i[vec_o]);
            p_vec_lowest_r8: assert (((active_i & ((64'd1 << vec_o) - 64'd1)) >> 1) == '0);
        end else begin
            p_vec_none_r8: assert ((active_i & SRC_USED) == '0);
        end
    end
endmodule

// File: rtl/sirq_ctrl.sv
module sirq_ctrl
    import sirq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic [NUM_SRC-1:0] irq_n_i,
    input  logic              bus_wr_i,
    input  logic [2:0]        bus_addr_i,
    input  logic [WORD_W-1:0] bus_wdata_i,
    output logic [WORD_W-1:0] bus_rdata_o,
    output logic              irq_o
);
    localparam logic [WORD_W-1:0] SENSE_WR = sense_writable();

    logic [WORD_W-1:0]  mask_hi_q, mask_lo_q, sense_q;
    logic [WORD_W-1:0]  pend_hi_w, pend_lo_w;
    logic [NUM_SRC-1:0] sync_n, edge_sel, clr, pend, mask_v, active;
    logic [VEC_W-1:0]   vec_id;
    logic               irq_q;
    reg_addr_e          addr;

    assign addr = reg_addr_e'(bus_addr_i);

    sirq_sync #(.W(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .d_i   (irq_n_i),
        .q_o   (sync_n)
    );

    // Translate between source order and the scrambled word layout.
    always_comb begin
        slot_t sl;
        mask_v    = '0;
        clr       = '0;
        edge_sel  = '0;
        pend_hi_w = '0;
        pend_lo_w = '0;
        for (int s = 0; s < NUM_SRC; s++) begin
            sl = slot_of(s);
            if (sl.valid) begin
                mask_v[s] = sl.hi ? mask_hi_q[sl.pos] : mask_lo_q[sl.pos];
                clr[s]    = bus_wr_i && bus_wdata_i[sl.pos] &&
                            (sl.hi ? (addr == A_PEND_HI) : (addr == A_PEND_LO));
                if (sl.hi) pend_hi_w[sl.pos] = pend[s];
                else       pend_lo_w[sl.pos] = pend[s];
            end
            if (has_sense(s)) edge_sel[s] = sense_q[sense_pos(s)];
        end
    end

    sirq_pend u_pend (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .sync_n_i   (sync_n),
        .edge_sel_i (edge_sel),
        .clr_i      (clr),
        .pend_o     (pend)
    );

    assign active = pend & mask_v;

    sirq_prio u_prio (
        .active_i (active),
        .vec_o    (vec_id)
    );

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            mask_hi_q <= '0;
            mask_lo_q <= '0;
            sense_q   <= '0;
            irq_q     <= 1'b0;
        end else begin
            if (bus_wr_i) begin
                case (addr)
                    A_MASK_HI: mask_hi_q <= bus_wdata_i;
                    A_MASK_LO: mask_lo_q <= bus_wdata_i;
                    A_SENSE:   sense_q   <= bus_wdata_i & SENSE_WR;
                    default:   ;
                endcase
            end
            irq_q <= |active;
        end
    end

    always_comb begin
        case (addr)
            A_MASK_HI: bus_rdata_o = mask_hi_q;
            A_MASK_LO: bus_rdata_o = mask_lo_q;
            A_PEND_HI: bus_rdata_o = pend_hi_w;
            A_PEND_LO: bus_rdata_o = pend_lo_w;
            A_SENSE:   bus_rdata_o = sense_q;
            A_VECTOR:  bus_rdata_o = {vec_id, {VEC_LSB{1'b0}}};
            default:   bus_rdata_o = '0;
        endcase
    end

    assign irq_o = irq_q;

    // R9: the output follows the encoder's verdict one clock later
    p_irq_rise_r9: assert property (@(posedge clk_i) disable iff (rst_i)
        (vec_id != '0) |=> irq_o);
    p_irq_fall_r9: assert property (@(posedge clk_i) disable iff (rst_i)
        (vec_id == '0) |=> !irq_o);

    // R7: sense bits outside the two groups never become set
    p_sense_clean_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        (sense_q & ~SENSE_WR) == '0);
endmodule

// File: tb/sirq_ctrl_tb.sv
module sirq_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] irq_n = '1;
    logic        wr = 1'b0;
    logic [2:0]  addr = 3'd5;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int checks = 0;
    int bad    = 0;
    bit cmp_on = 1'b0;
    bit done   = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    sirq_ctrl dut_i (
        .clk_i(clk), .rst_i(rst), .irq_n_i(irq_n), .bus_wr_i(wr),
        .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq)
    );

    // ---- placement rules taken from the requirements ----
    function automatic bit b_hi(int s);
        return (s >= 16 && s <= 31) || s >= 48;
    endfunction
    function automatic int b_bit(int s);
        if (s < 16)  return 16 - s;
        if (s < 19)  return 18 - s;
        if (s < 31)  return 33 - s;
        if (s == 31) return 15;
        if (s < 48)  return 63 - s;
        return s - 32;
    endfunction
    function automatic int b_sense(int s);
        if (s >= 19 && s <= 25) return 33 - s;
        if (s >= 48)            return 79 - s;
        return -1;
    endfunction

    // ---- behavioural reference ----
    logic [63:0] m_s1 = '1, m_s2 = '1, m_prev = '1, m_pend = '0;
    logic [31:0] m_mhi = '0, m_mlo = '0, m_sense = '0;
    logic        m_irq = 1'b0;

    function automatic bit m_masked_in(int s);
        return b_hi(s) ? m_mhi[b_bit(s)] : m_mlo[b_bit(s)];
    endfunction
    function automatic int m_vec();
        for (int s = 1; s < 64; s++)
            if (m_pend[s] && m_masked_in(s)) return s;
        return 0;
    endfunction

    always @(posedge clk) begin
        logic [63:0] np;
        bit e, c;
        np = '0;
        if (rst) begin
            m_s1 <= '1; m_s2 <= '1; m_prev <= '1; m_pend <= '0;
            m_mhi <= '0; m_mlo <= '0; m_sense <= '0; m_irq <= 1'b0;
        end else begin
            for (int s = 1; s < 64; s++) begin
                e = (b_sense(s) >= 0) && m_sense[b_sense(s)];
                c = wr && (addr == (b_hi(s) ? 3'd2 : 3'd3)) && wdata[b_bit(s)];
                if (e) np[s] = (m_pend[s] && !c) || (m_prev[s] && !m_s2[s]);
                else   np[s] = !m_s2[s];
            end
            m_irq  <= (m_vec() != 0);
            m_pend <= np;
            m_s1 <= irq_n; m_s2 <= m_s1; m_prev <= m_s2;
            if (wr) begin
                if (addr == 3'd0) m_mhi <= wdata;
                if (addr == 3'd1) m_mlo <= wdata;
                if (addr == 3'd4) m_sense <= wdata & 32'hFFFF_7F00;
            end
        end
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Every-clock comparison against the model (R8, R9).
    always @(negedge clk) begin
        if (cmp_on && !rst) begin
            chk("R9 irq_o", {31'b0, irq}, {31'b0, m_irq});
            if (addr == 3'd5) chk("R8 vector", rdata, 32'(m_vec()) << 26);
        end
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
        #1;
    endtask
    task automatic wr_reg(logic [2:0] a, logic [31:0] d);
        @(negedge clk); #1;
        wr = 1'b1; addr = a; wdata = d;
        @(negedge clk); #1;
        wr = 1'b0; addr = 3'd5; wdata = '0;
    endtask
    task automatic rd_reg(logic [2:0] a, output logic [31:0] d);
        @(negedge clk); #1;
        addr = a;
        @(negedge clk);
        d = rdata;
        #1 addr = 3'd5;
    endtask
    task automatic rd_chk(string req, logic [2:0] a, logic [31:0] exp);
        logic [31:0] d;
        rd_reg(a, d);
        chk(req, d, exp);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++; checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] exp_hi, exp_lo;
        tick(4);
        rst = 1'b0;
        tick(1);
        cmp_on = 1'b1;

        // R1: reset state
        rd_chk("R1 mask_hi", 3'd0, 32'h0);
        rd_chk("R1 mask_lo", 3'd1, 32'h0);
        rd_chk("R1 pend_hi", 3'd2, 32'h0);
        rd_chk("R1 pend_lo", 3'd3, 32'h0);
        rd_chk("R1 sense",   3'd4, 32'h0);
        rd_chk("R1 vector",  3'd5, 32'h0);
        chk("R1 irq_o", {31'b0, irq}, 32'h0);

        // R3: mask read-back; R10: unused addresses
        wr_reg(3'd0, 32'hA5A5_1234);
        wr_reg(3'd1, 32'h0F0F_F0F0);
        rd_chk("R3 mask_hi", 3'd0, 32'hA5A5_1234);
        rd_chk("R3 mask_lo", 3'd1, 32'h0F0F_F0F0);
        wr_reg(3'd5, 32'hFFFF_FFFF);
        wr_reg(3'd6, 32'hFFFF_FFFF);
        wr_reg(3'd7, 32'hFFFF_FFFF);
        rd_chk("R10 addr6", 3'd6, 32'h0);
        rd_chk("R10 addr7", 3'd7, 32'h0);
        rd_chk("R10 mask_hi kept", 3'd0, 32'hA5A5_1234);
        rd_chk("R10 sense kept",   3'd4, 32'h0);
        wr_reg(3'd0, 32'h0);
        wr_reg(3'd1, 32'h0);

        // R2: every source lands at its own word and bit (level mode)
        for (int s = 0; s < 64; s++) begin
            irq_n[s] = 1'b0;
            tick(4);
            exp_hi = '0; exp_lo = '0;
            if (s != 0) begin
                if (b_hi(s)) exp_hi[b_bit(s)] = 1'b1;
                else         exp_lo[b_bit(s)] = 1'b1;
            end
            rd_chk($sformatf("R2 src%0d hi", s), 3'd2, exp_hi);
            rd_chk($sformatf("R2 src%0d lo", s), 3'd3, exp_lo);
            irq_n[s] = 1'b1;
            tick(4);
        end

        // R5: latency of the level path (source 7 -> low bit 9)
        @(negedge clk); #1;
        addr = 3'd3; irq_n[7] = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk("R5 not yet after 2 edges", rdata, 32'h0);
        @(negedge clk);
        chk("R5 set after 3 edges", rdata, 32'h0000_0200);
        #1 addr = 3'd5;

        // R4: write-1 to a level bit has no lasting effect
        wr_reg(3'd3, 32'h0000_0200);
        rd_chk("R4 level bit still set", 3'd3, 32'h0000_0200);
        irq_n[7] = 1'b1;
        tick(4);
        rd_chk("R5 level bit follows release", 3'd3, 32'h0);

        // R7: only the group bits are writable
        wr_reg(3'd4, 32'hFFFF_FFFF);
        rd_chk("R7 sense writable bits", 3'd4, 32'hFFFF_7F00);
        // R7: source 5 has no sense bit and stays level
        irq_n[5] = 1'b0; tick(4); irq_n[5] = 1'b1; tick(4);
        rd_chk("R7 src5 stays level", 3'd3, 32'h0);
        wr_reg(3'd4, 32'h0);

        // R6: edge latch for source 20 (sense bit 13, high bit 13)
        wr_reg(3'd4, 32'h2000_2000);   // src20 bit13, src50 bit29
        irq_n[20] = 1'b0; tick(2); irq_n[20] = 1'b1; tick(5);
        rd_chk("R6 edge latched after release", 3'd2, 32'h0000_2000);
        wr_reg(3'd2, 32'hFFFF_DFFF);
        rd_chk("R4 write-0 keeps edge bit", 3'd2, 32'h0000_2000);
        wr_reg(3'd2, 32'h0000_2000);
        rd_chk("R4 write-1 clears edge bit", 3'd2, 32'h0);
        // R6: held-low port source 50 (high bit 18) does not re-latch
        irq_n[50] = 1'b0; tick(5);
        rd_chk("R6 port edge latched", 3'd2, 32'h0004_0000);
        wr_reg(3'd2, 32'h0004_0000);
        tick(5);
        rd_chk("R6 no re-latch while low", 3'd2, 32'h0);
        irq_n[50] = 1'b1;
        wr_reg(3'd4, 32'h0);
        tick(4);

        // R8: priority and masking
        wr_reg(3'd0, 32'hFFFF_FFFF);
        wr_reg(3'd1, 32'hFFFF_FFFF);
        irq_n[40] = 1'b0; irq_n[5] = 1'b0; irq_n[50] = 1'b0;
        tick(4);
        rd_chk("R8 lowest wins", 3'd5, 32'd5 << 26);
        chk("R9 irq high", {31'b0, irq}, 32'h1);
        wr_reg(3'd1, 32'hFFFF_F7FF);   // mask off source 5 (low bit 11)
        rd_chk("R8 next source", 3'd5, 32'd40 << 26);
        wr_reg(3'd1, 32'hFF7F_F7FF);   // mask off source 40 (low bit 23)
        rd_chk("R8 high-word source", 3'd5, 32'd50 << 26);

        // R9: output drops one clock after the last mask goes away
        wr_reg(3'd0, 32'h0);
        chk("R9 still high one edge after", {31'b0, irq}, 32'h1);
        @(negedge clk);
        chk("R9 low next edge", {31'b0, irq}, 32'h0);
        rd_chk("R8 vector empty", 3'd5, 32'h0);
        irq_n = '1;
        tick(5);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule